// File: doc/BRIEF.md
# Two-Phase Explicit-Address Microprogram Sequencer

This block steps through a constant control store. Each row holds a control word, two candidate successor addresses and a small condition-select code. No address counter exists. Each row names its successor outright, and a pair of address registers hands the chosen successor back to the row decoder.

A full microinstruction takes two clock cycles, driven by an internal phase bit:

- **Decode phase.** The *current* register drives a one-hot row decoder. The active row's control word appears on `ctrl_o`. The successor picked by the row's condition code and the flag inputs is captured into the *pending* register.
- **Transfer phase.** The decoder is idle, so `ctrl_o` is all zero, and the pending register is copied into the current register.

A datapath around the block consumes `ctrl_o` during decode cycles and feeds status bits back on `flags_i`.

The store contents are computed at elaboration from the row index, so the sequence is fixed and known to software that builds around it.

Top module: `ucseq_top`

## Requirements
- R1: A synchronous reset clears both address registers to 0 and selects the decode phase. In the first cycle after reset, `addr_o` is 0 and `ctrl_o` carries row 0's control word.
- R2: During a decode cycle, `ctrl_o` equals the control word of the row addressed by `addr_o`, and exactly one decoder line is active.
- R3: During a transfer cycle, `ctrl_o` is all zero.
- R4: Decode and transfer cycles strictly alternate. `addr_o` holds its value across the decode-to-transfer edge and takes the pending address at the transfer-to-decode edge.
- R5: A row whose select code is 0 always continues at its first successor, whatever `flags_i` holds. A select code above the number of flags behaves the same way.
- R6: A row whose select code k lies in 1..NFLAG samples `flags_i[k-1]` during its decode cycle. A 1 picks the second successor and a 0 picks the first.
- R7: For row a, the store contents are as follows, each truncated to its field width: control word = 37·a + 17; first successor = a + 1; second successor = 3·a + 1; select code = a. With the defaults this gives an 8-bit control word, 4-bit addresses and select code = a mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flags_i | input | NFLAG | Condition flags sampled in decode cycles |
| ctrl_o | output | CTRL_W | Control word of the active row; zero in transfer cycles |
| addr_o | output | ADDR_W | Current-address register contents |

## Verification
The bench builds the block with its defaults: 16 rows, an 8-bit control word and three flags.

With these values every row is reachable through its first successor. The rows with select codes 1 to 3 test each flag in turn, and the rows with a select code of 0 (every fourth row) let the bench hold flags at all-ones and check that those rows still take their first successor.

Random flag patterns, together with long all-ones and all-zero stretches, drive both successors of every conditional row. A reset applied in the middle of a transfer cycle shows that the phase and both registers restart cleanly.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  typedef enum logic {PH_DECODE = 1'b0, PH_XFER = 1'b1} phase_e;

  // Store contents as functions of the row index; callers truncate.
  function automatic int unsigned word_of_row(int unsigned a);
    return a * 37 + 17;
  endfunction

  function automatic int unsigned succ_a_of_row(int unsigned a);
    return a + 1;
  endfunction

  function automatic int unsigned succ_b_of_row(int unsigned a);
    return a * 3 + 1;
  endfunction

  function automatic int unsigned cond_of_row(int unsigned a);
    return a;
  endfunction

endpackage

// File: rtl/ucseq_matrix.sv
module ucseq_matrix #(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] row_addr,
  output logic [(1<<ADDR_W)-1:0] lines,
  output logic [CTRL_W-1:0] word,
  output logic [ADDR_W-1:0] succ_a,
  output logic [ADDR_W-1:0] succ_b,
  output logic [SEL_W-1:0]  cond
);
  localparam int ROWS = 1 << ADDR_W;

  logic [CTRL_W-1:0] word_tab [ROWS];
  logic [ADDR_W-1:0] sa_tab   [ROWS];
  logic [ADDR_W-1:0] sb_tab   [ROWS];
  logic [SEL_W-1:0]  cond_tab [ROWS];

  // One decoder line and one constant row per address.
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign lines[i]    = strobe && (row_addr == ADDR_W'(i));
    assign word_tab[i] = CTRL_W'(ucseq_pkg::word_of_row(i));
    assign sa_tab[i]   = ADDR_W'(ucseq_pkg::succ_a_of_row(i));
    assign sb_tab[i]   = ADDR_W'(ucseq_pkg::succ_b_of_row(i));
    assign cond_tab[i] = SEL_W'(ucseq_pkg::cond_of_row(i));
  end

  // Wired-OR read-out: only an active line contributes.
  always_comb begin
    word   = '0;
    succ_a = '0;
    succ_b = '0;
    cond   = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (lines[r]) begin
        word   = word   | word_tab[r];
        succ_a = succ_a | sa_tab[r];
        succ_b = succ_b | sb_tab[r];
        cond   = cond   | cond_tab[r];
      end
    end
  end

  AST_SINGLE_ROW: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $onehot(lines)); // R2
  AST_DARK_MATRIX: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (lines == '0)); // R3

endmodule

// File: rtl/ucseq_branch.sv
module ucseq_branch #(
  parameter int ADDR_W = 4,
  parameter int NFLAG  = 3,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  cond,
  input  logic [NFLAG-1:0]  flags,
  input  logic [ADDR_W-1:0] succ_a,
  input  logic [ADDR_W-1:0] succ_b,
  output logic              take_b,
  output logic [ADDR_W-1:0] pick
);
  always_comb begin
    take_b = 1'b0;
    for (int k = 1; k <= NFLAG; k++) begin
      if (cond == SEL_W'(k)) take_b = flags[k-1];
    end
    pick = take_b ? succ_b : succ_a;
  end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top #(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 8,
  parameter int NFLAG  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAG-1:0]  flags_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] addr_o
);
  import ucseq_pkg::*;

  localparam int ROWS  = 1 << ADDR_W;
  localparam int SEL_W = (NFLAG < 1) ? 1 : $clog2(NFLAG + 1);

  phase_e            ph_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] pend_q;
  logic              in_decode;
  logic [ROWS-1:0]   lines;
  logic [CTRL_W-1:0] row_word;
  logic [ADDR_W-1:0] row_sa, row_sb, next_addr;
  logic [SEL_W-1:0]  row_cond;
  logic              take_b;

  assign in_decode = (ph_q == PH_DECODE);

  ucseq_matrix #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .SEL_W(SEL_W)) u_matrix (
    .clk(clk), .rst(rst), .strobe(in_decode), .row_addr(cur_q),
    .lines(lines), .word(row_word), .succ_a(row_sa), .succ_b(row_sb),
    .cond(row_cond)
  );

  ucseq_branch #(.ADDR_W(ADDR_W), .NFLAG(NFLAG), .SEL_W(SEL_W)) u_branch (
    .cond(row_cond), .flags(flags_i), .succ_a(row_sa), .succ_b(row_sb),
    .take_b(take_b), .pick(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      pend_q <= '0;
      ph_q   <= PH_DECODE;
    end else if (in_decode) begin
      pend_q <= next_addr;
      ph_q   <= PH_XFER;
    end else begin
      cur_q  <= pend_q;
      ph_q   <= PH_DECODE;
    end
  end

  assign ctrl_o = row_word;
  assign addr_o = cur_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cur_q == '0 && pend_q == '0 && ph_q == PH_DECODE)); // R1
  AST_QUIET_XFER: assert property (@(posedge clk) disable iff (rst)
    !in_decode |-> (ctrl_o == '0)); // R3
  AST_HOLD_CUR: assert property (@(posedge clk) disable iff (rst)
    in_decode |=> ($stable(cur_q) && !in_decode)); // R4
  AST_LOAD_CUR: assert property (@(posedge clk) disable iff (rst)
    !in_decode |=> (cur_q == $past(pend_q) && in_decode)); // R4
  AST_UNCOND_A: assert property (@(posedge clk) disable iff (rst)
    (in_decode && row_cond == '0) |=> (pend_q == $past(row_sa))); // R5
  AST_TAKEN_B: assert property (@(posedge clk) disable iff (rst)
    (in_decode && take_b) |=> (pend_q == $past(row_sb))); // R6

endmodule

// File: tb/ucseq_top_bench.sv
`timescale 1ns/1ps
module ucseq_top_bench;
  localparam int AW = 4, CW = 8, NF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NF-1:0] flags_i = '0;
  logic [CW-1:0] ctrl_o;
  logic [AW-1:0] addr_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ucseq_top #(.ADDR_W(AW), .CTRL_W(CW), .NFLAG(NF)) u_ucseq_top (
    .clk(clk), .rst(rst), .flags_i(flags_i), .ctrl_o(ctrl_o), .addr_o(addr_o)
  );

  // Reference model state
  int m_addr = 0, m_pend = 0, m_phase = 0;
  string addr_tag = "R1";

  function automatic int exp_word(int a);
    return (37 * a + 17) % 256;
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic compare_now();
    check(addr_tag, addr_o, m_addr);
    if (m_phase == 0) check("R2/R7 ctrl in decode", ctrl_o, exp_word(m_addr));
    else              check("R3 ctrl in transfer", ctrl_o, 0);
  endtask

  task automatic model_step();
    int sel;
    if (rst) begin
      m_addr = 0; m_pend = 0; m_phase = 0; addr_tag = "R1";
    end else if (m_phase == 0) begin
      sel = m_addr % 4;
      if (sel >= 1 && sel <= NF && flags_i[sel-1]) begin
        m_pend = (3 * m_addr + 1) % 16; addr_tag = "R6 taken";
      end else begin
        m_pend = (m_addr + 1) % 16;
        addr_tag = (sel == 0) ? "R5 unconditional" : "R6 not taken";
      end
      m_phase = 1;
    end else begin
      m_addr = m_pend; m_phase = 0;
    end
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
      case (mode)
        0: flags_i = NF'($urandom);
        1: flags_i = '1;
        default: flags_i = '0;
      endcase
      @(posedge clk);
      #1 model_step();
    end
  endtask

  initial begin
    @(posedge clk); @(posedge clk);
    #1 model_step();
    @(negedge clk); rst = 1'b0;
    // R1: first cycle after reset
    check("R1 reset addr", addr_o, 0);
    check("R1 reset ctrl", ctrl_o, exp_word(0));
    @(posedge clk); #1 model_step();
    run(60, 1);   // all flags high: R5 rows still take first successor
    run(60, 2);   // all flags low
    run(300, 0);  // random flags
    // mid-run reset during a transfer cycle
    while (m_phase != 1) run(1, 0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 model_step();
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset addr", addr_o, 0);
    check("R1 mid-run reset ctrl", ctrl_o, exp_word(0));
    @(posedge clk); #1 model_step();
    run(200, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule